// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This clocked controller sits between a host and an asynchronous static memory of 65,536 words by 4 bits with separate data-in and data-out buses. The host presents a request (read or write, address, write data) under a valid/ready handshake. The controller then drives the memory's 16-bit address, active-low chip enable, active-low write enable and 4-bit write data, and shapes them so that every timing minimum of the memory is met. For reads it captures the data-out bus and returns it with a one-cycle response pulse.

A write happens only while both strobes are low, and the strobe that rises first ends it. This controller always lets write enable end the write. Chip enable, address and data stay unchanged for one further clock after write enable rises. Every timing minimum is a nanosecond parameter. The controller converts each one into a whole number of clock cycles, rounding up, for the clock period it is given. Because the data buses are separate, no bus turnaround is needed.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, mem_ce_n and mem_we_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. While req_ready is 1 both strobes are high. A request held valid during a busy cycle is carried out exactly once, after the current cycle ends.
- R3: On a write, mem_ce_n falls on the accepting edge together with the new address and data. mem_we_n falls exactly one clock later. mem_we_n is never low while mem_ce_n is high.
- R4: mem_we_n stays low for exactly WE_CYC clocks. WE_CYC is the largest of 1, ceil(WE_PULSE_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS), ceil(ADDR_SETUP_NS/CLK_NS)-1, ceil(CE_SETUP_NS/CLK_NS)-1 and ceil(WRITE_CYCLE_NS/CLK_NS)-2. This meets the pulse, data-setup, address-setup and enable-setup minimums.
- R5: mem_addr and mem_din do not change while mem_ce_n is low. On a write, mem_ce_n rises exactly one clock after mem_we_n rises, so write enable always ends the write.
- R6: On a read, mem_ce_n stays low with mem_we_n high for exactly RD_CYC clocks. RD_CYC is the largest of 1, ceil(READ_ACCESS_NS/CLK_NS) and ceil(READ_CYCLE_NS/CLK_NS). mem_dout is sampled on the edge that raises mem_ce_n.
- R7: rsp_valid is a single-cycle pulse, produced once per read and never for a write. It coincides with the return of req_ready. rsp_rdata holds the sampled read data.
- R8: A value written to an address is returned by a later read of that address.
- R9: req_ready is low for WE_CYC+2 clocks after a write is accepted and for RD_CYC clocks after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request word address |
| req_wdata | input | 4 | Request write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | output | 4 | Data to memory |
| mem_dout | input | 4 | Data from memory |

## Verification
The hardest case to reach from the ports is a request that arrives while a cycle is already running. It has to wait and then run exactly once. The bench builds it by raising a read to the same address in the cycle right after a write is accepted, and holding req_valid through the whole write. It then checks the read data, the total latency and the count of chip-enable falls. Strobe timing is measured in nanoseconds on every memory edge. The bench uses a configuration in which the write-enable pulse and the read access each span several clocks, so a wrong cycle count changes the measured widths.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int CLK_NS         = 10,
  parameter int WE_PULSE_NS    = 8,
  parameter int DATA_SETUP_NS  = 8,
  parameter int ADDR_SETUP_NS  = 9,
  parameter int CE_SETUP_NS    = 9,
  parameter int WRITE_CYCLE_NS = 12,
  parameter int READ_ACCESS_NS = 12,
  parameter int READ_CYCLE_NS  = 12,
  parameter int AW             = 16,
  parameter int DW             = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_din,
  input  logic [DW-1:0] mem_dout
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WE_CYC = mx(mx(mx(1, cyc(WE_PULSE_NS)), mx(cyc(DATA_SETUP_NS), cyc(ADDR_SETUP_NS) - 1)),
                             mx(cyc(CE_SETUP_NS) - 1, cyc(WRITE_CYCLE_NS) - 2));
  localparam int RD_CYC = mx(1, mx(cyc(READ_ACCESS_NS), cyc(READ_CYCLE_NS)));
  localparam int CW     = $clog2(mx(WE_CYC, RD_CYC) + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WLOW, S_WEND, S_READ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_din   <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr  <= req_addr;
          mem_ce_n  <= 1'b0;
          req_ready <= 1'b0;
          if (req_write) begin
            mem_din <= req_wdata;
            st      <= S_WSET;
          end else begin
            cnt <= CW'(RD_CYC - 1);
            st  <= S_READ;
          end
        end
        S_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= CW'(WE_CYC - 1);
          st       <= S_WLOW;
        end
        S_WLOW: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          st       <= S_WEND;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WEND: begin
          mem_ce_n  <= 1'b1;
          req_ready <= 1'b1;
          st        <= S_IDLE;
        end
        S_READ: if (cnt == '0) begin
          rsp_rdata <= mem_dout;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          req_ready <= 1'b1;
          st        <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int WE_CYC = 1,
  parameter int RD_CYC = 1,
  parameter int AW     = 16,
  parameter int DW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_din
);

  logic [15:0] we_low, ce_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low <= '0;
      ce_low <= '0;
    end else begin
      we_low <= mem_we_n ? 16'd0 : we_low + 16'd1;
      ce_low <= mem_ce_n ? 16'd0 : ce_low + 16'd1;
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n)); // R2
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R3
  AST_WE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n)); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low == 16'(WE_CYC))); // R4
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_din))); // R5
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n)); // R5
  AST_READ_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ce_low == 16'(RD_CYC))); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din));

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb;
  localparam int CLK = 10, WEP = 25, DSU = 8, ASU = 9, CSU = 9, WC = 12, ACC = 32, RC = 12;

  function automatic int cd(input int ns); return (ns + CLK - 1) / CLK; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
  localparam int W  = mx(mx(mx(1, cd(WEP)), mx(cd(DSU), cd(ASU) - 1)), mx(cd(CSU) - 1, cd(WC) - 2));
  localparam int RD = mx(1, mx(cd(ACC), cd(RC)));

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n;
  logic [3:0] rsp_rdata, mem_din, mem_dout;
  logic [15:0] mem_addr;

  always #5 clk = ~clk;

  sram_cycle_ctrl #(.CLK_NS(CLK), .WE_PULSE_NS(WEP), .DATA_SETUP_NS(DSU), .ADDR_SETUP_NS(ASU),
    .CE_SETUP_NS(CSU), .WRITE_CYCLE_NS(WC), .READ_ACCESS_NS(ACC), .READ_CYCLE_NS(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [3:0] model [logic [15:0]];
  always @(mem_addr or mem_ce_n or mem_we_n)
    mem_dout = (!mem_ce_n && mem_we_n && model.exists(mem_addr)) ? model[mem_addr] : 4'h0;
  always @(posedge mem_we_n) if (rst_n && !mem_ce_n) model[mem_addr] = mem_din;

  bit started = 0, wrote = 0;
  longint t_ce_f, t_we_f, t_we_r, t_bus;
  int n_ce_fall = 0, n_rsp = 0, n_ops = 0;

  always @(mem_addr or mem_din) t_bus = $time;
  always @(negedge mem_ce_n) if (started) begin t_ce_f = $time; n_ce_fall++; end
  always @(negedge mem_we_n) if (started) begin
    t_we_f = $time;
    chk(!mem_ce_n && (t_we_f - t_ce_f == CLK), "R3 WE falls one clock after CE", int'(t_we_f - t_ce_f), CLK);
  end
  always @(posedge mem_we_n) if (started) begin
    t_we_r = $time;
    wrote = 1;
    chk(t_we_r - t_we_f == W * CLK, "R4 WE pulse width", int'(t_we_r - t_we_f), W * CLK);
    chk((t_we_r - t_we_f >= WEP) && (t_we_r - t_ce_f >= CSU) && (t_we_r - t_bus >= mx(ASU, DSU)),
        "R4 setup minimums", int'(t_we_r - t_bus), mx(ASU, DSU));
  end
  always @(posedge mem_ce_n) if (started) begin
    chk(t_bus <= t_ce_f, "R5 bus stable while CE low", int'(t_bus), int'(t_ce_f));
    if (wrote) begin
      chk($time - t_we_r == CLK, "R5 CE rises one clock after WE", int'($time - t_we_r), CLK);
      wrote = 0;
    end else begin
      chk(($time - t_ce_f == RD * CLK) && ($time - t_ce_f >= ACC), "R6 read access window",
          int'($time - t_ce_f), RD * CLK);
    end
  end
  always @(negedge clk) if (started && rsp_valid) n_rsp++;

  task automatic op(input bit wr, input logic [15:0] a, input logic [3:0] d, output logic [3:0] rd);
    int busy;
    bit got;
    got = 0; busy = 0; rd = 'x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    n_ops++;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin got = 1; rd = rsp_rdata; end
      if (req_ready) break;
      busy++;
    end
    chk(busy == (wr ? W + 2 : RD), "R9 busy length", busy, wr ? W + 2 : RD);
    chk(got == !wr, "R7 response only for reads", got, !wr);
  endtask

  function automatic logic [15:0] sweep_addr(input int i);
    if (i == 0) return 16'h0000;
    if (i == 1) return 16'hFFFF;
    return 16'(i * 16'h0551 + 16'h0013);
  endfunction

  localparam int N = 40;

  initial begin
    logic [3:0] r;
    int n;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && req_ready && !rsp_valid, "R1 reset state",
        {mem_ce_n, mem_we_n, req_ready, rsp_valid}, 4'b1110);
    rst_n = 1; started = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && req_ready, "R1 idle after reset", {mem_ce_n, mem_we_n, req_ready}, 3'b111);

    for (int i = 0; i < N; i++) op(1'b1, sweep_addr(i), 4'((i * 7 + 3) ^ (i >> 2)), r);
    for (int i = N - 1; i >= 0; i--) begin
      op(1'b0, sweep_addr(i), 4'h0, r);
      chk(r == 4'((i * 7 + 3) ^ (i >> 2)), "R8 read back", r, 4'((i * 7 + 3) ^ (i >> 2)));
    end
    op(1'b1, 16'h1234, 4'hC, r);
    op(1'b1, 16'h1234, 4'h5, r);
    op(1'b0, 16'h1234, 4'h0, r);
    chk(r == 4'h5, "R8 overwrite", r, 5);

    // R2: read held valid through a running write
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'hBEEF; req_wdata = 4'h9;
    @(posedge clk); #1;
    req_write = 0;
    n_ops += 2;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!req_ready) chk(req_valid, "R2 request held", 0, 0);
      if (req_ready && !rsp_valid && n > 1 && n < W + 3) chk(0, "R2 early ready", n, W + 3);
    end while (!rsp_valid && n < 100);
    req_valid = 0;
    chk(rsp_rdata == 4'h9, "R2 held read data", rsp_rdata, 9);
    chk(n == W + RD + 4, "R2 held request latency", n, W + RD + 4);
    repeat (RD + 4) @(negedge clk);
    chk(n_ce_fall == n_ops, "R2 each request run once", n_ce_fall, n_ops);
    chk(n_rsp == N + 2, "R7 response count", n_rsp, N + 2);
    chk(req_ready && mem_ce_n && mem_we_n, "R2 idle at end", {req_ready, mem_ce_n, mem_we_n}, 3'b111);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule